// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Slave

This block is the bus-facing half of a small I2C/SMBus port device. It runs on a fast system clock and oversamples the two bus lines. It finds START and STOP conditions and answers to a 7-bit address. The upper four bits of that address are a parameter, and the lower three come from strap pins. It acknowledges every byte it accepts by pulling SDA low in the ninth clock. The bus itself is never driven high: the block only asserts a pull-down request, and the pad logic turns that into an open-drain output.

In a write transaction, the first byte after the address is a command byte. Its low bits become the register index shown on `reg_idx`. Every later byte in the same transaction becomes a one-cycle write strobe to that index. In a read transaction, the block shifts out the byte presented on `reg_rdata` for the current index, MSB first. A read that directly follows the address (a receive-byte read) uses whichever index the last command byte selected. A write of the command followed by a repeated START and a read gives a read-byte transaction. The pointer never advances by itself.

An active-low reset returns the bus engine to idle and clears the command pointer, even in the middle of a transfer.

Top module: `i2c_cmd_slave`

## Requirements
- R1: After reset, `sda_pull` is 0, `reg_wr` is 0 and `reg_idx` is 0.
- R2: The device answers to address {ADDR_HI, addr_pins}, with ADDR_HI = 4'b0011 by default. The address byte carries the address in bits 7:1 and R/W in bit 0, where 1 means read. On a match with either R/W value, `sda_pull` is 1 throughout the ninth SCL high period.
- R3: If the address does not match, the device never asserts `sda_pull` or `reg_wr` and does not change `reg_idx` until the next START.
- R4: In a write, the first byte after the address is acknowledged, and its low IDX_W bits appear on `reg_idx` before the next byte begins.
- R5: Each later byte of a write is acknowledged and causes exactly one single-cycle `reg_wr` pulse, with `reg_wdata` equal to the byte and `reg_idx` equal to the stored pointer. The pulse occurs while SCL is low.
- R6: In a read, the device shifts out `reg_rdata[reg_idx]` MSB first, starting at the SCL fall that ends the address acknowledge. A read directly after the address uses the pointer from the most recent command byte.
- R7: In the ninth clock of a read byte, the device releases SDA. If the master acknowledges, the same register is sent again. If the master does not acknowledge, SDA stays released until STOP or START.
- R8: A repeated START restarts the address phase without a STOP, so a command write followed by Sr and a read returns the newly selected register.
- R9: Asserting `rst_n` low during a transfer returns the engine to idle. It releases SDA, clears the pointer to 0 and causes no write. A following transaction works normally.
- R10: A single-clock-cycle pulse on SCL or on SDA during an SCL high period changes nothing: the byte is received intact with one write and no false START or STOP.
- R11: After a STOP, the device ignores bus clocks and data until a START, even when the clocked bits equal its own write address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad (wired bus value) |
| addr_pins | input | 3 | Strapped low three bits of the slave address |
| sda_pull | output | 1 | 1 requests the SDA open-drain pull-down |
| reg_idx | output | IDX_W | Register index held by the command pointer |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_wdata | output | 8 | Byte written with `reg_wr` |
| reg_rdata | input | 8 | Contents of the register at `reg_idx` |

## Verification
Writes with two different pointers and several data bytes show that the pointer is held rather than advanced. A receive-byte read followed by a read-byte read with a repeated START shows which pointer value each read uses. Address bytes with wrong strap bits, a changed strap, and an own-address byte clocked after a STOP separate a true match from idle behaviour. Injected one-cycle pulses on each line and a reset in the middle of a byte test the filter and the reinitialisation.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_IGNORE
  } bus_state_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CMD,
    BK_DATA
  } byte_kind_t;

  // Two-of-three vote across a sample window.
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // Full 7-bit device address from the fixed part and the strap pins.
  function automatic logic [6:0] own_addr(input logic [3:0] hi, input logic [2:0] pins);
    return {hi, pins};
  endfunction

  // Address byte carries the address in bits 7:1.
  function automatic logic addr_hit(input logic [6:0] want, input logic [7:0] rx);
    return rx[7:1] == want;
  endfunction

  // Byte role that follows an acknowledged byte of a write.
  function automatic byte_kind_t next_kind(input byte_kind_t k);
    return (k == BK_ADDR) ? BK_CMD : BK_DATA;
  endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  import i2c_cmd_pkg::*;

  localparam int WIN = 3;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [WIN-1:0]         win_q;
  logic                   filt_q;

  // Idle bus is high, so every stage resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q[0] <= line_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sync_q[i] <= sync_q[i-1];
      end
      win_q  <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
      filt_q <= maj3(win_q);
    end
  end

  assign line_o = filt_q;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  // SDA edges only count as conditions while SCL stays high on both samples.
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_f,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       rdata,
  output logic             sda_pull,
  output logic             wr_stb,
  output logic [7:0]       wdata,
  output logic [IDX_W-1:0] cmd_ptr,
  output logic             in_ignore
);
  import i2c_cmd_pkg::*;

  localparam logic [3:0] LAST_RX = 4'd8;
  localparam logic [3:0] LAST_TX = 4'd7;

  bus_state_t       state_q;
  byte_kind_t       kind_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       shreg_q;
  logic             rw_q;
  logic             mack_q;
  logic             pull_q;
  logic             wr_q;
  logic [7:0]       wdata_q;
  logic [IDX_W-1:0] cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= BK_ADDR;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      pull_q    <= 1'b0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      cmd_q     <= '0;
    end else begin
      wr_q <= 1'b0;
      if (start_ev) begin
        state_q   <= ST_RX;
        kind_q    <= BK_ADDR;
        bit_cnt_q <= '0;
        pull_q    <= 1'b0;
      end else if (stop_ev) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise && bit_cnt_q != LAST_RX) begin
              shreg_q   <= {shreg_q[6:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && bit_cnt_q == LAST_RX) begin
              bit_cnt_q <= '0;
              case (kind_q)
                BK_ADDR: begin
                  if (addr_hit(dev_addr, shreg_q)) begin
                    rw_q    <= shreg_q[0];
                    pull_q  <= 1'b1;
                    state_q <= ST_ACK;
                  end else begin
                    state_q <= ST_IGNORE;
                  end
                end
                BK_CMD: begin
                  cmd_q   <= shreg_q[IDX_W-1:0];
                  pull_q  <= 1'b1;
                  state_q <= ST_ACK;
                end
                default: begin
                  wr_q    <= 1'b1;
                  wdata_q <= shreg_q;
                  pull_q  <= 1'b1;
                  state_q <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (kind_q == BK_ADDR && rw_q) begin
                state_q   <= ST_TX;
                shreg_q   <= rdata;
                pull_q    <= ~rdata[7];
                bit_cnt_q <= '0;
              end else begin
                state_q <= ST_RX;
                pull_q  <= 1'b0;
                kind_q  <= next_kind(kind_q);
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt_q == LAST_TX) begin
                state_q <= ST_TXACK;
                pull_q  <= 1'b0;
              end else begin
                shreg_q   <= {shreg_q[6:0], 1'b0};
                pull_q    <= ~shreg_q[6];
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_f;
            end else if (scl_fall) begin
              if (mack_q) begin
                state_q   <= ST_TX;
                shreg_q   <= rdata;
                pull_q    <= ~rdata[7];
                bit_cnt_q <= '0;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull  = pull_q;
  assign wr_stb    = wr_q;
  assign wdata     = wdata_q;
  assign cmd_ptr   = cmd_q;
  assign in_ignore = (state_q == ST_IGNORE);

endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave #(
  parameter logic [3:0] ADDR_HI     = 4'b0011,
  parameter int         IDX_W       = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [2:0]       addr_pins,
  output logic             sda_pull,
  output logic [IDX_W-1:0] reg_idx,
  output logic             reg_wr,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata
);
  import i2c_cmd_pkg::*;

  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] clean_lines;
  logic             scl_f, sda_f;
  logic             scl_rise, scl_fall, start_ev, stop_ev;
  logic             in_ignore;
  logic [6:0]       dev_addr;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_glitch_filter #(.SYNC_STAGES(SYNC_STAGES)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (clean_lines[g])
    );
  end

  assign scl_f    = clean_lines[0];
  assign sda_f    = clean_lines[1];
  assign dev_addr = own_addr(ADDR_HI, addr_pins);

  i2c_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_byte_engine #(.IDX_W(IDX_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .dev_addr  (dev_addr),
    .rdata     (reg_rdata),
    .sda_pull  (sda_pull),
    .wr_stb    (reg_wr),
    .wdata     (reg_wdata),
    .cmd_ptr   (reg_idx),
    .in_ignore (in_ignore)
  );

endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_f,
  input logic             stop_ev,
  input logic             in_ignore,
  input logic             sda_pull,
  input logic             reg_wr,
  input logic [IDX_W-1:0] reg_idx
);

  p_reset_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_pull && !reg_wr));

  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ignore |-> (!sda_pull && !reg_wr));

  p_ptr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $stable(reg_idx));

  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_wr_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !scl_f);

  // R6/R2: SDA drive only moves while SCL is low.
  p_pull_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_pull));

  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_pull && !in_ignore));

endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_f     (scl_f),
  .stop_ev   (stop_ev),
  .in_ignore (in_ignore),
  .sda_pull  (sda_pull),
  .reg_wr    (reg_wr),
  .reg_idx   (reg_idx)
);

// File: tb/i2c_cmd_slave_test.sv
module i2c_cmd_slave_test;
  localparam int IDX_W = 2;
  localparam int Q     = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             scl_m = 1'b1;
  logic             sda_m = 1'b1;
  logic [2:0]       pins = 3'b101;
  logic             sda_pull;
  logic [IDX_W-1:0] reg_idx;
  logic             reg_wr;
  logic [7:0]       reg_wdata;
  logic [7:0]       reg_rdata;
  logic [7:0]       dev_bank [4];
  logic             sda_line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int wr_log[$];
  int exp_bank[4];
  int exp_cmd;

  always #5 clk = ~clk;

  assign sda_line  = sda_m & ~sda_pull;
  assign reg_rdata = dev_bank[reg_idx];

  i2c_cmd_slave #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_pins(pins), .sda_pull(sda_pull), .reg_idx(reg_idx),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Register bank seen by the slave, plus a log of write strobes.
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) dev_bank[i] = 8'h00;
    end else if (reg_wr) begin
      dev_bank[reg_idx] = reg_wdata;
      wr_log.push_back((int'(reg_idx) << 8) | int'(reg_wdata));
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  // One SCL period; gl[0] pulses SCL low, gl[1] flips SDA, for one cycle mid-high.
  task automatic bus_bit(input logic b, input logic [1:0] gl, output logic ln, output logic pl);
    scl_m = 1'b0; wq();
    sda_m = b;    wq();
    scl_m = 1'b1; wq();
    ln = sda_line;
    pl = sda_pull;
    if (gl[0]) begin scl_m = 1'b0; @(negedge clk); scl_m = 1'b1; end
    if (gl[1]) begin sda_m = ~sda_m; @(negedge clk); sda_m = ~sda_m; end
    wq();
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wq();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string tag,
                           input int gl_bit = -1, input logic [1:0] gl_kind = 2'b00);
    logic ln, pl;
    logic any_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(v[i], (i == gl_bit) ? gl_kind : 2'b00, ln, pl);
      if (pl) any_pull = 1'b1;
    end
    bus_bit(1'b1, 2'b00, ln, pl);
    chk({tag, " no drive in data bits"}, int'(any_pull), 0);
    chk({tag, " ninth-clock ack"}, int'(pl), int'(exp_ack));
  endtask

  task automatic recv_byte(input logic mack, input int exp_v, input string tag);
    logic ln, pl;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, 2'b00, ln, pl);
      v[i] = ln;
    end
    bus_bit(mack ? 1'b0 : 1'b1, 2'b00, ln, pl);
    chk({tag, " read byte"}, int'(v), exp_v);
    chk({tag, " released in ninth clock"}, int'(pl), 0);
  endtask

  task automatic expect_write(input string tag, input int idx, input int data);
    chk({tag, " write count"}, wr_log.size(), 1);
    if (wr_log.size() > 0) chk({tag, " write index/data"}, wr_log[0], (idx << 8) | data);
    wr_log.delete();
  endtask

  task automatic expect_no_write(input string tag);
    chk({tag, " no write"}, wr_log.size(), 0);
    wr_log.delete();
  endtask

  function automatic logic [7:0] abyte(input logic [2:0] p, input logic rd);
    return {4'b0011, p, rd};
  endfunction

  // Model update for a data byte written under the current pointer.
  task automatic model_data(input logic [7:0] v, input string tag, input int gl_bit = -1,
                            input logic [1:0] gl_kind = 2'b00);
    send_byte(v, 1'b1, tag, gl_bit, gl_kind);
    expect_write(tag, exp_cmd, int'(v));
    exp_bank[exp_cmd] = int'(v);
  endtask

  task automatic model_cmd(input int c, input string tag);
    send_byte(8'(c), 1'b1, tag);
    exp_cmd = c;
    chk({tag, " pointer on reg_idx"}, int'(reg_idx), c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ln, pl;
    for (int i = 0; i < 4; i++) exp_bank[i] = 0;
    exp_cmd = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sda_pull", int'(sda_pull), 0);
    chk("R1 reg_wr", int'(reg_wr), 0);
    chk("R1 reg_idx", int'(reg_idx), 0);

    // R2, R4, R5: write pointer 2 then two bytes; pointer does not advance.
    bus_start();
    send_byte(abyte(3'b101, 1'b0), 1'b1, "R2 write address");
    model_cmd(2, "R4 command 2");
    model_data(8'hA5, "R5 first data");
    model_data(8'h3C, "R5 second data same index");
    bus_stop();
    chk("R4 pointer held after stop", int'(reg_idx), 2);

    // R10: glitches on SCL and on SDA inside data bytes.
    bus_start();
    send_byte(abyte(3'b101, 1'b0), 1'b1, "R2 write address");
    model_cmd(1, "R4 command 1");
    model_data(8'h96, "R10 scl glitch", 2, 2'b01);
    model_data(8'h69, "R10 sda glitch", 5, 2'b10);
    bus_stop();

    // R6: receive-byte read uses the last pointer (1).
    bus_start();
    send_byte(abyte(3'b101, 1'b1), 1'b1, "R2 read address");
    recv_byte(1'b0, exp_bank[1], "R6 receive-byte");
    bus_stop();

    // R8, R7: pointer write, repeated START, read with ACK then NACK.
    bus_start();
    send_byte(abyte(3'b101, 1'b0), 1'b1, "R8 write address");
    model_cmd(2, "R8 command 2");
    bus_start();
    send_byte(abyte(3'b101, 1'b1), 1'b1, "R8 read address after Sr");
    recv_byte(1'b1, exp_bank[2], "R8 read-byte");
    recv_byte(1'b0, exp_bank[2], "R7 repeat after master ack");
    send_byte(8'h00, 1'b0, "R7 released after nack");
    expect_no_write("R7 after nack");
    bus_stop();

    // R3: wrong strap bits in address.
    bus_start();
    send_byte(abyte(3'b100, 1'b0), 1'b0, "R3 foreign address");
    send_byte(8'h01, 1'b0, "R3 following byte");
    send_byte(8'h55, 1'b0, "R3 second byte");
    expect_no_write("R3 foreign transaction");
    chk("R3 pointer unchanged", int'(reg_idx), 2);
    bus_stop();

    // R2: changed strap pins select the device.
    pins = 3'b010;
    repeat (4) @(negedge clk);
    bus_start();
    send_byte(abyte(3'b010, 1'b0), 1'b1, "R2 new strap address");
    model_cmd(0, "R4 command 0");
    model_data(8'h5A, "R5 data to index 0");
    bus_stop();
    bus_start();
    send_byte(abyte(3'b101, 1'b1), 1'b0, "R2 old strap not matched");
    bus_stop();

    // R11: own address clocked with no START after a STOP.
    send_byte(abyte(3'b010, 1'b0), 1'b0, "R11 after stop");
    send_byte(8'h03, 1'b0, "R11 second byte");
    expect_no_write("R11 idle bus");
    bus_stop();

    // R9: reset in the middle of a data byte.
    bus_start();
    send_byte(abyte(3'b010, 1'b0), 1'b1, "R9 write address");
    model_cmd(3, "R9 command 3");
    for (int i = 7; i >= 4; i--) bus_bit(1'b1, 2'b00, ln, pl);
    scl_m = 1'b0; wq();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) exp_bank[i] = 0;
    exp_cmd = 0;
    repeat (10) @(negedge clk);
    chk("R9 sda released", int'(sda_pull), 0);
    chk("R9 pointer cleared", int'(reg_idx), 0);
    expect_no_write("R9 aborted byte");
    bus_stop();
    bus_start();
    send_byte(abyte(3'b010, 1'b0), 1'b1, "R9 address after reset");
    model_cmd(3, "R9 command after reset");
    model_data(8'hC3, "R9 data after reset");
    bus_stop();
    bus_start();
    send_byte(abyte(3'b010, 1'b1), 1'b1, "R9 read address");
    recv_byte(1'b0, exp_bank[3], "R9 read back");
    bus_stop();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule